// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four shared PCI interrupt request lines onto sixteen legacy interrupt-controller inputs. Each request line has an 8-bit steering register that names the controller input it drives. A steering value of 16 or more leaves the line unconnected. Every controller input is the OR of all request lines currently steered to it. A line-by-input level map holds this state, with one bit per (controller input, request line) pair at bit index input*4 + line.

Software writes the steering registers through a write port with byte enables. Every cycle, one of two update kinds applies to the level map. TRACK copies the live level of each connected request line into its map bit. REBUILD applies when a write lands on the steering registers: it clears the whole map and refills it from the live levels under the new steering. Both kinds commit on the same clock edge as the write, so the registered controller outputs change one clock after a level change or a steering write.

Two combinational helpers sit beside the router. A route query reports, for a chosen request line, whether it is connected and to which input. A slot swizzle turns a device slot number and its interrupt pin into a request-line index, using a rotation in which slot 1 pin A lands on line 0.

Top module: `pirq_router`

## Requirements
- R1: After reset every steering register holds 0x80, so the query reports all four lines as not connected, and `irq_out` is all zero.
- R2: A write with `wr_addr` equal to 0x60 targets the steering registers. Byte lane i of `wr_data` (bits 8i+7..8i) loads the register for request line i. The new value is visible on the query one clock after the write.
- R3: A write whose `wr_addr` is not 0x60 leaves all steering registers and `irq_out` unchanged. This includes 0x5C, 0x64 and the unaligned 0x61.
- R4: A request line whose steering value is 16 or more has no effect on any `irq_out` bit, whatever its level. The value 15 is still a valid connection.
- R5: `irq_out[k]` is the OR of the levels of all request lines steered to k. It updates one clock after a level change.
- R6: With two request lines steered to the same input, that input stays high until both lines are low.
- R7: A steering write rebuilds the map from the current levels. One clock after the write, the old input drops and the new input shows the line's live level.
- R8: The query for pin `qry_pin` gives `qry_en`=1 and `qry_irq` equal to the steering value when that value is below 16. Otherwise it gives `qry_en`=0 and `qry_irq`=0xFF, which reads as -1.
- R9: `swz_pirq` = (`swz_intx` + `swz_slot` - 1) mod 4, combinationally. Here intx 0..3 means pins A..D.
- R10: A byte lane whose `wr_be` bit is 0 leaves its steering register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the written dword |
| wr_be | input | 4 | Byte enables, one per lane |
| wr_data | input | 32 | Write data, lane i in bits 8i+7..8i |
| pirq_lvl | input | 4 | Live levels of request lines 0..3 |
| irq_out | output | 16 | Registered controller input levels |
| qry_pin | input | 2 | Request line to query |
| qry_en | output | 1 | Queried line is connected |
| qry_irq | output | 8 | Connected input number, or 0xFF |
| swz_slot | input | 5 | Device slot number |
| swz_intx | input | 2 | Device interrupt pin, 0..3 for A..D |
| swz_pirq | output | 2 | Request line that the device pin reaches |

## Verification
The assertions take three things for granted. Request-line levels are sampled synchronously. A write is a single-cycle strobe. Reset holds long enough to load every steering register. The bench drives all inputs on the falling edge and pulses `wr_en` for exactly one cycle, so every level and steering change is seen by exactly one rising edge. For the same reason, the one-clock output latency that the properties check is the latency the stimulus produces.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
    typedef enum logic [0:0] {
        UPD_TRACK   = 1'b0,
        UPD_REBUILD = 1'b1
    } upd_kind_e;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
    parameter int NUM_PIRQ    = 4,
    parameter int NUM_LINES   = 16,
    parameter int ROUTE_W     = 8,
    parameter int ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h60,
    parameter logic [ROUTE_W-1:0] RESET_ROUTE = 8'h80,
    localparam int PIRQ_W = $clog2(NUM_PIRQ),
    localparam int DATA_W = NUM_PIRQ * ROUTE_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [NUM_PIRQ-1:0]              wr_be,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [PIRQ_W-1:0]                qry_pin,
    output logic                             qry_en,
    output logic [ROUTE_W-1:0]               qry_irq,
    output logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_nx,
    output logic                             wr_hit
);
    logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_q;

    assign wr_hit = wr_en && (wr_addr == BASE_ADDR) && (|wr_be);

    always_comb begin
        for (int p = 0; p < NUM_PIRQ; p++) begin
            route_nx[p] = (wr_hit && wr_be[p]) ? wr_data[p*ROUTE_W +: ROUTE_W] : route_q[p];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PIRQ; p++) route_q[p] <= RESET_ROUTE;
        end else begin
            route_q <= route_nx;
        end
    end

    always_comb begin
        qry_en  = route_q[qry_pin] < ROUTE_W'(NUM_LINES);
        qry_irq = qry_en ? route_q[qry_pin] : '1;
    end

    // R3
    out_of_range_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr != BASE_ADDR)) |=> $stable(route_q));
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
    import pirq_router_pkg::*;
#(
    parameter int NUM_PIRQ  = 4,
    parameter int NUM_LINES = 16,
    parameter int ROUTE_W   = 8,
    localparam int PIRQ_W = $clog2(NUM_PIRQ),
    localparam int LINE_W = $clog2(NUM_LINES),
    localparam int MAP_W  = NUM_PIRQ * NUM_LINES
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PIRQ-1:0]              pirq_lvl,
    input  logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_nx,
    input  logic                             rebuild,
    output logic [NUM_LINES-1:0]             irq_out
);
    upd_kind_e                    upd_kind;
    logic [MAP_W-1:0]             map_q;
    logic [MAP_W-1:0]             map_nx;
    logic [NUM_LINES-1:0]         line_nx;
    logic [NUM_PIRQ-1:0]          valid_nx;
    logic [LINE_W+PIRQ_W-1:0]     idx;

    always_comb begin
        for (int p = 0; p < NUM_PIRQ; p++) begin
            valid_nx[p] = route_nx[p] < ROUTE_W'(NUM_LINES);
        end
    end

    assign upd_kind = rebuild ? UPD_REBUILD : UPD_TRACK;

    always_comb begin
        idx = '0;
        unique case (upd_kind)
            UPD_REBUILD: map_nx = '0;
            UPD_TRACK:   map_nx = map_q;
            default:     map_nx = map_q;
        endcase
        for (int p = 0; p < NUM_PIRQ; p++) begin
            if (valid_nx[p]) begin
                idx         = {route_nx[p][LINE_W-1:0], PIRQ_W'(p)};
                map_nx[idx] = pirq_lvl[p];
            end
        end
    end

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_or
        assign line_nx[k] = |map_nx[k*NUM_PIRQ +: NUM_PIRQ];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q   <= '0;
            irq_out <= '0;
        end else begin
            map_q   <= map_nx;
            irq_out <= line_nx;
        end
    end

    // R5
    quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pirq_lvl == '0) |=> (irq_out == '0));

    for (genvar p = 0; p < NUM_PIRQ; p++) begin : g_chk
        logic col_any;
        always_comb begin
            col_any = 1'b0;
            for (int k = 0; k < NUM_LINES; k++) col_any = col_any | map_q[k*NUM_PIRQ + p];
        end
        // R5
        line_follows_pirq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pirq_lvl[p] && valid_nx[p]) |=> irq_out[$past(route_nx[p][LINE_W-1:0])]);
        // R4
        disabled_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_nx[p] |=> !col_any);
    end
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
    parameter int NUM_PIRQ = 4,
    parameter int SLOT_W   = 5,
    localparam int PIRQ_W = $clog2(NUM_PIRQ)
) (
    input  logic [SLOT_W-1:0] swz_slot,
    input  logic [PIRQ_W-1:0] swz_intx,
    output logic [PIRQ_W-1:0] swz_pirq
);
    logic [SLOT_W-1:0] sum;
    logic              unused_hi;

    assign sum       = swz_slot + SLOT_W'(swz_intx) - SLOT_W'(1);
    assign swz_pirq  = sum[PIRQ_W-1:0];
    assign unused_hi = ^sum[SLOT_W-1:PIRQ_W];
endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
    parameter int NUM_PIRQ  = 4,
    parameter int NUM_LINES = 16,
    parameter int ROUTE_W   = 8,
    parameter int ADDR_W    = 8,
    parameter int SLOT_W    = 5,
    localparam int PIRQ_W = $clog2(NUM_PIRQ),
    localparam int DATA_W = NUM_PIRQ * ROUTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [NUM_PIRQ-1:0]  wr_be,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [NUM_PIRQ-1:0]  pirq_lvl,
    output logic [NUM_LINES-1:0] irq_out,
    input  logic [PIRQ_W-1:0]    qry_pin,
    output logic                 qry_en,
    output logic [ROUTE_W-1:0]   qry_irq,
    input  logic [SLOT_W-1:0]    swz_slot,
    input  logic [PIRQ_W-1:0]    swz_intx,
    output logic [PIRQ_W-1:0]    swz_pirq
);
    logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_nx;
    logic                             wr_hit;

    pirq_route_regs #(
        .NUM_PIRQ(NUM_PIRQ), .NUM_LINES(NUM_LINES), .ROUTE_W(ROUTE_W), .ADDR_W(ADDR_W)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .qry_pin(qry_pin), .qry_en(qry_en), .qry_irq(qry_irq),
        .route_nx(route_nx), .wr_hit(wr_hit)
    );

    pirq_level_map #(
        .NUM_PIRQ(NUM_PIRQ), .NUM_LINES(NUM_LINES), .ROUTE_W(ROUTE_W)
    ) i_map (
        .clk(clk), .rst_n(rst_n), .pirq_lvl(pirq_lvl), .route_nx(route_nx),
        .rebuild(wr_hit), .irq_out(irq_out)
    );

    pirq_swizzle #(.NUM_PIRQ(NUM_PIRQ), .SLOT_W(SLOT_W)) i_swz (
        .swz_slot(swz_slot), .swz_intx(swz_intx), .swz_pirq(swz_pirq)
    );
endmodule

// File: tb/test_pirq_router.sv
module test_pirq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  pirq_lvl = '0;
    logic [15:0] irq_out;
    logic [1:0]  qry_pin = '0;
    logic        qry_en;
    logic [7:0]  qry_irq;
    logic [4:0]  swz_slot = '0;
    logic [1:0]  swz_intx = '0;
    logic [1:0]  swz_pirq;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pirq_router i_pirq_router (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data), .pirq_lvl(pirq_lvl), .irq_out(irq_out), .qry_pin(qry_pin),
        .qry_en(qry_en), .qry_irq(qry_irq), .swz_slot(swz_slot), .swz_intx(swz_intx),
        .swz_pirq(swz_pirq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic lvl(input logic [3:0] v);
        @(negedge clk);
        pirq_lvl = v;
        @(negedge clk);
    endtask

    task automatic query(input string tag, input logic [1:0] pin, input logic en, input logic [7:0] irq);
        qry_pin = pin;
        #1;
        chk({tag, " en"}, {15'd0, qry_en}, {15'd0, en});
        chk({tag, " irq"}, {8'd0, qry_irq}, {8'd0, irq});
    endtask

    task automatic t_reset;
        chk("R1 irq_out", irq_out, 16'h0000);
        for (int p = 0; p < 4; p++) query("R1 query", 2'(p), 1'b0, 8'hFF);
    endtask

    task automatic t_disabled;
        lvl(4'hF);
        chk("R4 all disabled", irq_out, 16'h0000);
    endtask

    task automatic t_route;
        wr(8'h60, 4'hF, 32'h8080_050A);
        chk("R7 rebuild from live", irq_out, 16'h0420);
        query("R2 pin0", 2'd0, 1'b1, 8'd10);
        query("R8 pin1", 2'd1, 1'b1, 8'd5);
        query("R8 pin2", 2'd2, 1'b0, 8'hFF);
    endtask

    task automatic t_level;
        lvl(4'h0);
        chk("R5 all low", irq_out, 16'h0000);
        lvl(4'b0010);
        chk("R5 pirq1", irq_out, 16'h0020);
        lvl(4'b0001);
        chk("R5 pirq0", irq_out, 16'h0400);
    endtask

    task automatic t_share;
        lvl(4'b0010);
        wr(8'h60, 4'b0100, 32'h0005_0000);
        chk("R10 masked lanes irq", irq_out, 16'h0020);
        query("R10 pin0 kept", 2'd0, 1'b1, 8'd10);
        query("R2 pin2 set", 2'd2, 1'b1, 8'd5);
        lvl(4'b0110);
        chk("R6 both high", irq_out, 16'h0020);
        lvl(4'b0100);
        chk("R6 one left", irq_out, 16'h0020);
        lvl(4'b0000);
        chk("R6 both low", irq_out, 16'h0000);
    endtask

    task automatic t_outside;
        lvl(4'b0001);
        wr(8'h64, 4'hF, 32'h0);
        wr(8'h5C, 4'hF, 32'h0);
        wr(8'h61, 4'hF, 32'h0);
        chk("R3 irq kept", irq_out, 16'h0400);
        query("R3 pin0 kept", 2'd0, 1'b1, 8'd10);
        query("R3 pin2 kept", 2'd2, 1'b1, 8'd5);
    endtask

    task automatic t_edge;
        wr(8'h60, 4'b1010, 32'h0F00_1000);
        lvl(4'b1010);
        chk("R4 value 16 off, 15 on", irq_out, 16'h8000);
        query("R8 pin1 sixteen", 2'd1, 1'b0, 8'hFF);
        query("R8 pin3 fifteen", 2'd3, 1'b1, 8'd15);
    endtask

    task automatic t_reroute;
        lvl(4'b0001);
        chk("R7 before", irq_out, 16'h0400);
        wr(8'h60, 4'b0001, 32'h0000_0003);
        chk("R7 moved", irq_out, 16'h0008);
        query("R7 pin0", 2'd0, 1'b1, 8'd3);
    endtask

    task automatic t_swizzle;
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 4; i++) begin
                swz_slot = 5'(s); swz_intx = 2'(i);
                #1;
                chk("R9 swizzle", {14'd0, swz_pirq}, {14'd0, 2'((i + s + 3) % 4)});
            end
        end
        swz_slot = 5'd31; swz_intx = 2'd0;
        #1;
        chk("R9 slot31", {14'd0, swz_pirq}, 16'd2);
    endtask

    initial begin
        #1_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_disabled;
        t_route;
        t_level;
        t_share;
        t_outside;
        t_edge;
        t_reroute;
        t_swizzle;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule